// File: doc/BRIEF.md
# I/O and Memory Region Decoder

This block watches each bus cycle and says which peripheral function owns the address. It takes an address, a qualifier that marks the cycle as I/O or memory, and a valid strobe. One cycle later it gives a one-hot region select, or a miss flag that lets the cycle be passed on to another target.

Two kinds of region sit side by side. Legacy regions sit at hard-wired addresses. Relocatable regions each have a base register that software writes. Every relocatable region has a fixed size that is a power of two, and its base is aligned to that size. A native-mode input switches the disk controller decode. When it is low, the fixed legacy command and control ports are decoded. When it is high, four programmable command and control windows are decoded instead.

Base registers are written and read back through a small configuration port. The value read back is the stored value, with the ignored low bits already cleared.

Top module: `io_region_decoder`

## Requirements
- R1: After synchronous reset, `region_sel` is 0, `region_miss` is 0, and every base register reads back 0.
- R2: I/O cycles (`bus_is_io`=1, address bits 31:16 zero) select these fixed bits:
  - bit 0 for 0x00-0x0F
  - bit 1 for 0x20-0x21
  - bit 2 for 0x40-0x43
  - bit 3 for 0x60 and 0x64
  - bit 4 for 0x61
  - bit 5 for 0x70-0x73
  - bit 6 for 0x80-0x8F
  - bit 7 for 0x92
  - bit 8 for 0xA0-0xA1
  - bit 9 for 0xC0-0xDF
  - bit 10 for 0xF0-0xF1
  - bit 11 for 0x4D0-0x4D1
  - bit 12 for 0xCF9
- R3: With `ide_native`=0, bit 13 decodes I/O 0x1F0-0x1F7 and 0x3F6, and bit 14 decodes 0x170-0x177 and 0x376. With `ide_native`=1 these two bits never assert.
- R4: Relocatable windows use `cfg_idx` 0..6 and select bits 16..22:
  - index 0: I/O, 8 bytes
  - index 1: I/O, 4 bytes
  - index 2: I/O, 8 bytes
  - index 3: I/O, 4 bytes
  - index 4: I/O, 16 bytes
  - index 5: I/O, 256 bytes
  - index 6: memory, 4096 bytes
  
  Indices 0..3 decode only when `ide_native`=1.
- R5: A base write stores `cfg_wdata` with the bits below the window size cleared. I/O windows also have bits 31:16 cleared. `cfg_rdata` returns the stored value.
- R6: A base register that holds zero disables its window.
- R7: I/O regions match only when `bus_is_io`=1, and memory regions match only when it is 0.
- R8: `region_sel` is one-hot or zero. When regions overlap, the lowest bit index wins. Every fixed region (bits 0..15) therefore beats every relocatable one.
- R9: `region_miss` asserts exactly for a valid cycle that matches no region. Cycles with `bus_valid`=0 give a zero select and no miss.
- R10: Outputs are registered. A cycle presented before clock edge k shows its result after edge k. A base write in the same cycle as a decode takes effect only from the next cycle.
- R11: Memory cycles to 0xFEC00000-0xFEC0001F select bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Cycle address |
| bus_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| bus_valid | input | 1 | Cycle strobe |
| ide_native | input | 1 | Disk controller native-mode enable |
| cfg_we | input | 1 | Base register write enable |
| cfg_idx | input | 3 | Base register index (0..6) |
| cfg_wdata | input | 32 | Base register write data |
| cfg_rdata | output | 32 | Stored base of the register at `cfg_idx` |
| region_sel | output | 23 | Registered one-hot region select |
| region_miss | output | 1 | Registered no-match flag |

## Verification
A fixed region and a relocatable window can both claim one address in the same cycle. The bench provokes this by placing the 16-byte window on top of the 0x20 interrupt-controller ports, and by stacking two relocatable windows on the same base. It then expects the lowest-index region in the select. A base write can also land in the same cycle as a decode to the address being moved. The scoreboard expects the old mapping for that cycle and the new mapping from the next one.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  localparam int ADDR_W  = 32;
  localparam int IO_W    = 16;
  localparam int N_FIXED = 16;
  localparam int N_RELOC = 7;
  localparam int N_SEL   = N_FIXED + N_RELOC;
  localparam int IDX_W   = $clog2(N_RELOC + 1);

  // fixed select bits whose enable depends on native mode
  localparam int SEL_DISK_PRI_LEG = 13;
  localparam int SEL_DISK_SEC_LEG = 14;

  // relocatable windows that exist only in native mode (indices 0..N-1)
  localparam int N_NATIVE_WIN = 4;

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [3:0]  tgt;
    logic        io;
  } span_t;

  localparam int N_SPAN = 19;

  localparam span_t SPANS [N_SPAN] = '{
    '{32'h0000_0000, 32'h0000_000F, 4'd0,  1'b1},
    '{32'h0000_0020, 32'h0000_0021, 4'd1,  1'b1},
    '{32'h0000_0040, 32'h0000_0043, 4'd2,  1'b1},
    '{32'h0000_0060, 32'h0000_0060, 4'd3,  1'b1},
    '{32'h0000_0064, 32'h0000_0064, 4'd3,  1'b1},
    '{32'h0000_0061, 32'h0000_0061, 4'd4,  1'b1},
    '{32'h0000_0070, 32'h0000_0073, 4'd5,  1'b1},
    '{32'h0000_0080, 32'h0000_008F, 4'd6,  1'b1},
    '{32'h0000_0092, 32'h0000_0092, 4'd7,  1'b1},
    '{32'h0000_00A0, 32'h0000_00A1, 4'd8,  1'b1},
    '{32'h0000_00C0, 32'h0000_00DF, 4'd9,  1'b1},
    '{32'h0000_00F0, 32'h0000_00F1, 4'd10, 1'b1},
    '{32'h0000_04D0, 32'h0000_04D1, 4'd11, 1'b1},
    '{32'h0000_0CF9, 32'h0000_0CF9, 4'd12, 1'b1},
    '{32'h0000_01F0, 32'h0000_01F7, 4'd13, 1'b1},
    '{32'h0000_03F6, 32'h0000_03F6, 4'd13, 1'b1},
    '{32'h0000_0170, 32'h0000_0177, 4'd14, 1'b1},
    '{32'h0000_0376, 32'h0000_0376, 4'd14, 1'b1},
    '{32'hFEC0_0000, 32'hFEC0_001F, 4'd15, 1'b0}
  };

  // log2 of each relocatable window size, and its address space
  localparam int WIN_LG [N_RELOC] = '{3, 2, 3, 2, 4, 8, 12};
  localparam logic [N_RELOC-1:0] WIN_IS_IO = 7'b011_1111;

endpackage

// File: rtl/io_dec_fixed.sv
module io_dec_fixed
  import io_dec_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0]      addr,
  input  logic               is_io,
  input  logic               native,
  output logic [N_FIXED-1:0] hit
);

  always_comb begin
    hit = '0;
    for (int i = 0; i < N_SPAN; i++) begin
      if ((SPANS[i].io == is_io) &&
          (addr >= AW'(SPANS[i].lo)) &&
          (addr <= AW'(SPANS[i].hi))) begin
        hit[SPANS[i].tgt] = 1'b1;
      end
    end
    if (native) begin
      hit[SEL_DISK_PRI_LEG] = 1'b0;
      hit[SEL_DISK_SEC_LEG] = 1'b0;
    end
  end

endmodule

// File: rtl/io_dec_reloc.sv
module io_dec_reloc
  import io_dec_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int IOW = IO_W,
  parameter int NW  = N_RELOC,
  parameter int IW  = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic [AW-1:0] addr,
  input  logic          is_io,
  input  logic          native,
  output logic [NW-1:0] hit
);

  localparam logic [AW-1:0] IO_SPAN = {{(AW-IOW){1'b0}}, {IOW{1'b1}}};

  logic [NW-1:0][AW-1:0] base_v;

  for (genvar g = 0; g < NW; g++) begin : g_win
    localparam int            LG      = WIN_LG[g];
    localparam bit            IS_IO   = WIN_IS_IO[g];
    localparam bit            NEED_NM = (g < N_NATIVE_WIN);
    localparam logic [AW-1:0] UPPER   = {AW{1'b1}} << LG;
    localparam logic [AW-1:0] KEEP    = IS_IO ? (UPPER & IO_SPAN) : UPPER;

    logic [AW-1:0] base_q;
    logic          enabled;

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
      end else if (cfg_we && (cfg_idx == IW'(g))) begin
        base_q <= cfg_wdata & KEEP;
      end
    end

    assign enabled  = (base_q != '0) && (is_io == IS_IO) && (!NEED_NM || native);
    assign hit[g]   = enabled && ((addr & UPPER) == base_q);
    assign base_v[g] = base_q;
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_idx < IW'(NW)) begin
      cfg_rdata = base_v[cfg_idx];
    end
  end

endmodule

// File: rtl/io_dec_prio.sv
module io_dec_prio #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  // isolate lowest set bit: lowest index has priority
  assign gnt = req & (~req + N'(1));

endmodule

// File: rtl/io_region_decoder.sv
module io_region_decoder
  import io_dec_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int IOW = IO_W,
  parameter int IW  = IDX_W,
  parameter int NS  = N_SEL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_is_io,
  input  logic          bus_valid,
  input  logic          ide_native,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  output logic [NS-1:0] region_sel,
  output logic          region_miss
);

  logic [N_FIXED-1:0] fixed_hit;
  logic [N_RELOC-1:0] reloc_hit;
  logic [NS-1:0]      req;
  logic [NS-1:0]      gnt;

  io_dec_fixed #(.AW(AW)) u_fixed (
    .addr   (bus_addr),
    .is_io  (bus_is_io),
    .native (ide_native),
    .hit    (fixed_hit)
  );

  io_dec_reloc #(.AW(AW), .IOW(IOW), .NW(N_RELOC), .IW(IW)) u_reloc (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .addr      (bus_addr),
    .is_io     (bus_is_io),
    .native    (ide_native),
    .hit       (reloc_hit)
  );

  // fixed regions occupy the low indices, so they win every overlap
  assign req = bus_valid ? {reloc_hit, fixed_hit} : '0;

  io_dec_prio #(.N(NS)) u_prio (
    .req (req),
    .gnt (gnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      region_sel  <= '0;
      region_miss <= 1'b0;
    end else begin
      region_sel  <= gnt;
      region_miss <= bus_valid && (req == '0);
    end
  end

endmodule

// File: rtl/io_region_decoder_chk.sv
module io_region_decoder_chk #(
  parameter int NS = 23
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_valid,
  input logic          bus_is_io,
  input logic          ide_native,
  input logic [NS-1:0] region_sel,
  input logic          region_miss
);

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (region_sel == '0 && !region_miss));

  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(region_sel));

  p_miss_excl_r9: assert property (@(posedge clk) disable iff (rst)
    region_miss |-> (region_sel == '0));

  p_answer_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_valid) && !$past(rst)) |-> (region_miss || region_sel != '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_valid) |-> (region_sel == '0 && !region_miss));

  p_legacy_off_r3: assert property (@(posedge clk) disable iff (rst)
    $past(ide_native) |-> (region_sel[14:13] == 2'b00));

  p_native_only_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(ide_native) |-> (region_sel[19:16] == 4'b0000));

  p_io_space_r7: assert property (@(posedge clk) disable iff (rst)
    $past(bus_is_io) |-> (!region_sel[15] && !region_sel[22]));

  p_mem_space_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_is_io) |-> (region_sel[14:0] == '0 && region_sel[21:16] == '0));

endmodule

bind io_region_decoder io_region_decoder_chk #(.NS(NS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_valid   (bus_valid),
  .bus_is_io   (bus_is_io),
  .ide_native  (ide_native),
  .region_sel  (region_sel),
  .region_miss (region_miss)
);

// File: tb/io_region_decoder_tb_top.sv
`timescale 1ns/1ps
module io_region_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic        bus_is_io = 1'b0;
  logic        bus_valid = 1'b0;
  logic        ide_native = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [22:0] region_sel;
  logic        region_miss;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [22:0] sel;
    logic        miss;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  logic [31:0] mdl_base [7];
  int          win_lg [7] = '{3, 2, 3, 2, 4, 8, 12};

  always #4 clk = ~clk;

  io_region_decoder dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_is_io(bus_is_io),
    .bus_valid(bus_valid), .ide_native(ide_native), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .region_sel(region_sel), .region_miss(region_miss)
  );

  function automatic int model(logic [31:0] a, logic io, logic nat);
    if (io && a[31:16] == 16'h0) begin
      if (a <= 32'h0F) return 0;
      if (a == 32'h20 || a == 32'h21) return 1;
      if (a >= 32'h40 && a <= 32'h43) return 2;
      if (a == 32'h60 || a == 32'h64) return 3;
      if (a == 32'h61) return 4;
      if (a >= 32'h70 && a <= 32'h73) return 5;
      if (a >= 32'h80 && a <= 32'h8F) return 6;
      if (a == 32'h92) return 7;
      if (a == 32'hA0 || a == 32'hA1) return 8;
      if (a >= 32'hC0 && a <= 32'hDF) return 9;
      if (a == 32'hF0 || a == 32'hF1) return 10;
      if (a == 32'h4D0 || a == 32'h4D1) return 11;
      if (a == 32'hCF9) return 12;
      if (!nat && ((a >= 32'h1F0 && a <= 32'h1F7) || a == 32'h3F6)) return 13;
      if (!nat && ((a >= 32'h170 && a <= 32'h177) || a == 32'h376)) return 14;
    end
    if (!io && a >= 32'hFEC0_0000 && a <= 32'hFEC0_001F) return 15;
    for (int r = 0; r < 7; r++) begin
      logic rio;
      rio = (r != 6);
      if (r < 4 && !nat) continue;
      if (mdl_base[r] == 32'h0) continue;
      if (rio != io) continue;
      if ((a & ~((32'h1 << win_lg[r]) - 1)) == mdl_base[r]) return 16 + r;
    end
    return -1;
  endfunction

  function automatic logic [31:0] keep_mask(int r);
    logic [31:0] m;
    m = ~((32'h1 << win_lg[r]) - 1);
    if (r != 6) m = m & 32'h0000_FFFF;
    return m;
  endfunction

  function automatic exp_t expect_of(logic [31:0] a, logic io, logic v, string tag);
    exp_t e;
    int   k;
    k = model(a, io, ide_native);
    e.sel  = (v && k >= 0) ? (23'h1 << k) : 23'h0;
    e.miss = v && (k < 0);
    e.tag  = tag;
    return e;
  endfunction

  task automatic drive(logic [31:0] a, logic io, logic v, string tag);
    @(negedge clk);
    bus_addr = a; bus_is_io = io; bus_valid = v; cfg_we = 1'b0;
    sb_q.push_back(expect_of(a, io, v, tag));
  endtask

  // base write; optional decode in the same cycle sees the old base
  task automatic cfg_write(int r, logic [31:0] d, logic [31:0] a, logic io, logic v, string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(r); cfg_wdata = d;
    bus_addr = a; bus_is_io = io; bus_valid = v;
    sb_q.push_back(expect_of(a, io, v, tag));
    mdl_base[r] = d & keep_mask(r);
  endtask

  task automatic check_rd(int r, string tag);
    @(negedge clk);
    cfg_we = 1'b0; bus_valid = 1'b0; cfg_idx = 3'(r);
    sb_q.push_back(expect_of(32'h0, 1'b0, 1'b0, tag));
    #1;
    checks++;
    if (cfg_rdata !== mdl_base[r]) begin
      failures++;
      $display("FAIL %s: base %0d readback actual=%h expected=%h", tag, r, cfg_rdata, mdl_base[r]);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (region_sel !== e.sel || region_miss !== e.miss) begin
        failures++;
        $display("FAIL %s: actual sel=%h miss=%b expected sel=%h miss=%b",
                 e.tag, region_sel, region_miss, e.sel, e.miss);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int r = 0; r < 7; r++) mdl_base[r] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (region_sel !== '0 || region_miss !== 1'b0) begin
      failures++;
      $display("FAIL R1: actual sel=%h miss=%b expected sel=0 miss=0", region_sel, region_miss);
    end
    for (int r = 0; r < 7; r++) check_rd(r, "R1 base reset");

    // R2: fixed legacy ports, edges and gaps
    drive(32'h00, 1, 1, "R2 0x00");   drive(32'h0F, 1, 1, "R2 0x0F");
    drive(32'h10, 1, 1, "R2 gap 0x10"); drive(32'h21, 1, 1, "R2 0x21");
    drive(32'h22, 1, 1, "R2 gap 0x22"); drive(32'h43, 1, 1, "R2 0x43");
    drive(32'h60, 1, 1, "R2 0x60");   drive(32'h61, 1, 1, "R2 0x61");
    drive(32'h64, 1, 1, "R2 0x64");   drive(32'h62, 1, 1, "R2 gap 0x62");
    drive(32'h73, 1, 1, "R2 0x73");   drive(32'h80, 1, 1, "R2 0x80");
    drive(32'h8F, 1, 1, "R2 0x8F");   drive(32'h92, 1, 1, "R2 0x92");
    drive(32'hA1, 1, 1, "R2 0xA1");   drive(32'hC0, 1, 1, "R2 0xC0");
    drive(32'hDF, 1, 1, "R2 0xDF");   drive(32'hF1, 1, 1, "R2 0xF1");
    drive(32'h4D0, 1, 1, "R2 0x4D0"); drive(32'h4D1, 1, 1, "R2 0x4D1");
    drive(32'hCF9, 1, 1, "R2 0xCF9"); drive(32'hCF8, 1, 1, "R2 gap 0xCF8");

    // R7: space qualifier and upper address bits
    drive(32'h20, 0, 1, "R7 mem at io addr");
    drive(32'h1_0020, 1, 1, "R7 io upper bits");

    // R11: interrupt router window
    drive(32'hFEC0_0000, 0, 1, "R11 low");
    drive(32'hFEC0_001F, 0, 1, "R11 high");
    drive(32'hFEC0_0020, 0, 1, "R11 past end");
    drive(32'hFEC0_0000, 1, 1, "R11 io space");

    // R3: legacy disk ports in compatibility mode
    drive(32'h1F0, 1, 1, "R3 pri cmd");  drive(32'h1F7, 1, 1, "R3 pri end");
    drive(32'h3F6, 1, 1, "R3 pri ctl");  drive(32'h170, 1, 1, "R3 sec cmd");
    drive(32'h376, 1, 1, "R3 sec ctl");  drive(32'h3F7, 1, 1, "R3 gap 0x3F7");

    // R5: masking of written bases
    cfg_write(0, 32'hFFFF_01F3, 32'h0, 0, 0, "R5 wr0");
    check_rd(0, "R5 io 8B mask");
    cfg_write(6, 32'hDEAD_BEEF, 32'h0, 0, 0, "R5 wr6");
    check_rd(6, "R5 mem 4K mask");
    cfg_write(5, 32'h1234_5678, 32'h0, 0, 0, "R5 wr5");
    check_rd(5, "R5 io 256B mask");
    cfg_write(1, 32'h0000_03F7, 32'h0, 0, 0, "R5 wr1");
    check_rd(1, "R5 io 4B mask");

    // R4: native windows off in compatibility mode, on in native mode
    drive(32'h1F0, 1, 1, "R4 compat still legacy");
    @(negedge clk); ide_native = 1'b1;
    drive(32'h1F3, 1, 1, "R4 native pri cmd");
    drive(32'h3F6, 1, 1, "R4 native pri ctl");
    drive(32'h170, 1, 1, "R3 legacy off native");
    drive(32'h376, 1, 1, "R3 legacy ctl off native");
    drive(32'hDEAD_B123, 0, 1, "R4 mem 4K window");
    drive(32'hDEAD_C000, 0, 1, "R4 mem past window");
    drive(32'h5600, 1, 1, "R4 256B window low");
    drive(32'h56FF, 1, 1, "R4 256B window high");

    // R6: zero base disables
    drive(32'h0000_0100, 0, 1, "R6 mem near zero");
    cfg_write(6, 32'h0000_0FFF, 32'h0, 0, 0, "R6 wr6 zero");
    drive(32'hDEAD_B123, 0, 1, "R6 cleared window");
    drive(32'h0000_0000, 0, 1, "R6 zero base addr");

    // R8: overlap, fixed beats relocatable, lower window beats higher
    cfg_write(4, 32'h0000_0020, 32'h0, 0, 0, "R8 wr4");
    drive(32'h20, 1, 1, "R8 fixed wins");
    drive(32'h25, 1, 1, "R8 reloc only");
    cfg_write(4, 32'h0000_5610, 32'h0, 0, 0, "R8 wr4 b");
    drive(32'h5615, 1, 1, "R8 lower window wins");
    drive(32'h5605, 1, 1, "R8 256B window");

    // R9: idle cycles and miss
    drive(32'h20, 1, 0, "R9 idle");
    drive(32'h7777, 1, 1, "R9 miss");
    drive(32'h7777, 1, 0, "R9 idle after miss");

    // R10: write and decode in the same cycle; back-to-back results
    cfg_write(2, 32'h0000_1000, 32'h1004, 1, 1, "R10 old map same cycle");
    drive(32'h1004, 1, 1, "R10 new map next cycle");
    drive(32'h61, 1, 1, "R10 stream a");
    drive(32'h1007, 1, 1, "R10 stream b");
    drive(32'hFEC0_0010, 0, 1, "R10 stream c");
    @(negedge clk); ide_native = 1'b0;
    drive(32'h1004, 1, 1, "R4 window off after mode drop");
    drive(32'h3F6, 1, 1, "R3 legacy back");
    drive(32'h0, 0, 0, "R10 drain");
    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R10: actual pending=%0d expected pending=0", sb_q.size());
    end
    finish_run();
  end

endmodule